// File: doc/BRIEF.md
# ADC Channel Formatter with Decimation

This block sits on one channel of the path from an analog-to-digital converter to a transmit-only parallel output bus. It takes 14-bit two's-complement samples, each qualified by a data-ready strobe, and turns them into 16-bit output words with a matching valid flag. A 2-bit mode input selects one of three behaviours. The channel can be off. It can send a free-running 16-bit test count in place of data. It can pass samples through, with the sample's sign bit copied into the upper bits.

A 4-bit decimation factor thins the kept events down to one out of every N. Mode and factor are static configuration inputs driven by a register file elsewhere. Whenever either of them changes, the decimator starts a fresh group, so the first event under a new setting is always kept. The test counter advances on every strobe of the channel A sample clock, given here as a qualifier in the block's own clock domain. It runs freely whatever the mode.

Top module: `adc_chan_fmt`

## Requirements
- R1: With mode 2'b00 (off), `word_vld_o` stays low one cycle later, whatever the strobes do.
- R2: Mode 2'b11 is reserved and behaves exactly like mode 2'b00: no valid words.
- R3: In mode 2'b01 each `cnt_tick_i` strobe is a qualified event whose word is the current test count. The count starts at 0 after reset, rises by one on every `cnt_tick_i` in any mode, and wraps from 16'hFFFF to 16'h0000.
- R4: In mode 2'b10 each `smp_vld_i` strobe is a qualified event whose word is the sample with bit 13 copied into bits 15 and 14.
- R5: A decimation factor of 0 or 1 keeps every qualified event.
- R6: A factor N from 2 to 15 keeps the first qualified event of each group of N consecutive qualified events, and drops the other N-1.
- R7: In a cycle where mode or factor differs from the previous cycle's value, the group restarts, and a qualified event in that cycle is kept.
- R8: Reset clears `word_o` and `word_vld_o`. A kept event shows on the outputs exactly one clock later with `word_vld_o` high. In every other cycle `word_vld_o` is low and `word_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 14 | Two's-complement ADC sample |
| smp_vld_i | input | 1 | Sample data-ready strobe |
| cnt_tick_i | input | 1 | Channel A sample clock strobe, advances the test count |
| mode_i | input | 2 | 00 off, 01 test count, 10 pass-through, 11 reserved (off) |
| decim_i | input | 4 | Decimation factor N |
| word_o | output | 16 | Formatted output word |
| word_vld_o | output | 1 | Output word valid |

## Verification
Several behaviours are checked by assertions on every cycle. Off and reserved modes must give no valid word. Pass-through words must be sign-extended. The test count must step by exactly one per tick, including the wrap. The decimator phase must stay below the factor, a configuration change must force a keep, and the output word must stay put when nothing is kept. Other behaviours can only be shown by the bench's scenarios, which compare against a cycle model. These are the exact count of dropped events in a group of N, the count value a word carries after a long run and a full wrap, and the correct restart when the factor changes in the middle of a group.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_CNT  = 2'b01,
    MODE_PASS = 2'b10,
    MODE_RSV  = 2'b11
  } fmt_mode_e;
endpackage

// File: rtl/adc_test_cnt.sv
module adc_test_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (adv_i) cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && (cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
  assert_cnt_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && (cnt_o == CNT_MAX) |=> cnt_o == '0);
  assert_cnt_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_o));
endmodule

// File: rtl/adc_decim.sv
module adc_decim #(
  parameter int DEC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DEC_W-1:0] factor_i,
  input  logic             qual_i,
  output logic             keep_o
);
  logic [DEC_W-1:0] ph_q, ph_eff, ph_inc, ph_d;
  logic             pass_all;

  // a restart acts as if the phase were already zero this cycle
  assign ph_eff   = restart_i ? '0 : ph_q;
  assign ph_inc   = ph_eff + 1'b1;
  assign pass_all = (factor_i <= DEC_W'(1));
  assign keep_o   = qual_i && (ph_eff == '0);

  always_comb begin
    ph_d = ph_eff;
    if (qual_i) begin
      if (pass_all || (ph_inc == factor_i)) ph_d = '0;
      else                                  ph_d = ph_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assert_restart_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i && qual_i |-> keep_o);
  assert_phase_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i && (factor_i > DEC_W'(1)) |-> ph_q < factor_i);
  assert_pass_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i && pass_all && qual_i |-> keep_o);
endmodule

// File: rtl/adc_chan_fmt.sv
module adc_chan_fmt
  import adc_fmt_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int OUT_W = 16,
  parameter int DEC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             smp_vld_i,
  input  logic             cnt_tick_i,
  input  logic [1:0]       mode_i,
  input  logic [DEC_W-1:0] decim_i,
  output logic [OUT_W-1:0] word_o,
  output logic             word_vld_o
);
  localparam int EXT_W = OUT_W - SMP_W;

  fmt_mode_e        mode;
  fmt_mode_e        mode_q;
  logic [DEC_W-1:0] decim_q;
  logic             cfg_chg;
  logic             qual;
  logic             keep;
  logic [OUT_W-1:0] cnt;
  logic [OUT_W-1:0] sext;
  logic [OUT_W-1:0] word_d;

  assign mode = fmt_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      decim_q <= '0;
    end else begin
      mode_q  <= mode;
      decim_q <= decim_i;
    end
  end

  assign cfg_chg = (mode != mode_q) || (decim_i != decim_q);

  always_comb begin
    unique case (mode)
      MODE_CNT:  qual = cnt_tick_i;
      MODE_PASS: qual = smp_vld_i;
      default:   qual = 1'b0;
    endcase
  end

  adc_test_cnt #(.CNT_W(OUT_W)) i_test_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (cnt_tick_i),
    .cnt_o  (cnt)
  );

  adc_decim #(.DEC_W(DEC_W)) i_decim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cfg_chg),
    .factor_i  (decim_i),
    .qual_i    (qual),
    .keep_o    (keep)
  );

  generate
    if (EXT_W > 0) begin : g_ext
      assign sext = {{EXT_W{smp_i[SMP_W-1]}}, smp_i};
    end else begin : g_trunc
      assign sext = smp_i[OUT_W-1:0];
    end
  endgenerate

  assign word_d = (mode == MODE_CNT) ? cnt : sext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= keep;
      if (keep) word_o <= word_d;
    end
  end

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> !word_vld_o);
  assert_rsv_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> !word_vld_o);
  assert_sign_ext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep && (mode_i == 2'b10) |=> word_o[OUT_W-1:SMP_W-1] == {(EXT_W+1){word_o[SMP_W-1]}});
  assert_cnt_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep && (mode_i == 2'b01) |=> word_o == $past(cnt));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !keep |=> !word_vld_o && $stable(word_o));
endmodule

// File: tb/test_adc_chan_fmt.sv
`timescale 1ns/1ps
module test_adc_chan_fmt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] smp_i = '0;
  logic        smp_vld_i = 1'b0;
  logic        cnt_tick_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  decim_i = '0;
  logic [15:0] word_o;
  logic        word_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [15:0] m_cnt = '0;
  int          m_ph = 0;
  logic [1:0]  m_mode = 2'b00;
  logic [3:0]  m_dec = '0;
  logic [15:0] e_word = '0;
  logic        e_vld = 1'b0;

  always #2.5 clk_i = ~clk_i;

  adc_chan_fmt i_adc_chan_fmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .cnt_tick_i(cnt_tick_i), .mode_i(mode_i), .decim_i(decim_i),
    .word_o(word_o), .word_vld_o(word_vld_o)
  );

  function automatic logic [15:0] sext(input logic [13:0] s);
    return {{2{s[13]}}, s};
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b11:   return "R2";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag);
    checks++;
    if (word_vld_o !== e_vld || word_o !== e_word) begin
      errors++;
      $display("FAIL %s: vld=%0b word=%h expected vld=%0b word=%h",
               tag, word_vld_o, word_o, e_vld, e_word);
    end
  endtask

  task automatic step(input logic [13:0] s, input logic v, input logic t,
                      input logic [1:0] m, input logic [3:0] d, input string tag);
    logic qual, chg, keep;
    int   ph;
    smp_i = s; smp_vld_i = v; cnt_tick_i = t; mode_i = m; decim_i = d;
    qual = (m == 2'b01) ? t : (m == 2'b10) ? v : 1'b0;
    chg  = (m != m_mode) || (d != m_dec);
    ph   = chg ? 0 : m_ph;
    keep = qual && (ph == 0);
    e_vld = keep;
    if (keep) e_word = (m == 2'b01) ? m_cnt : sext(s);
    if (qual) m_ph = (d <= 1) ? 0 : ((ph + 1 == int'(d)) ? 0 : ph + 1);
    else      m_ph = ph;
    if (t) m_cnt = m_cnt + 16'd1;
    m_mode = m; m_dec = d;
    @(posedge clk_i);
    #1;
    check(tag);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #1;
    check("R8 reset");
    rst_ni = 1'b1;

    // R1 / R2: off and reserved ignore all strobes
    for (int i = 0; i < 6; i++) step(14'h1abc, 1'b1, 1'b1, 2'b00, 4'd0, "R1");
    for (int i = 0; i < 6; i++) step(14'h0123, 1'b1, 1'b1, 2'b11, 4'd0, "R2");

    // R4: pass-through sign extension, negative and positive extremes
    step(14'h2000, 1'b1, 1'b0, 2'b10, 4'd0, "R4");
    step(14'h1fff, 1'b1, 1'b0, 2'b10, 4'd0, "R4");
    step(14'h3fff, 1'b1, 1'b0, 2'b10, 4'd0, "R4");
    step(14'h0000, 1'b1, 1'b0, 2'b10, 4'd0, "R4");

    // R8: sparse strobes, word holds between kept events
    for (int i = 0; i < 12; i++)
      step(14'(i * 37), (i % 3) == 0, 1'b0, 2'b10, 4'd1, "R8");

    // R5: factor 0 and 1 keep every event
    for (int i = 0; i < 8; i++) step(14'(i + 5), 1'b1, 1'b0, 2'b10, 4'd0, "R5");
    for (int i = 0; i < 8; i++) step(14'(i + 9), 1'b1, 1'b0, 2'b10, 4'd1, "R5");

    // R6: factor 3 and 15
    for (int i = 0; i < 12; i++) step(14'(i * 101), 1'b1, 1'b0, 2'b10, 4'd3, "R6");
    for (int i = 0; i < 32; i++) step(14'(i * 7), 1'b1, 1'b0, 2'b10, 4'd15, "R6");

    // R7: factor change mid-group, mode change mid-group
    for (int i = 0; i < 2; i++) step(14'h0111, 1'b1, 1'b0, 2'b10, 4'd4, "R7");
    step(14'h0222, 1'b1, 1'b0, 2'b10, 4'd5, "R7");
    step(14'h0333, 1'b1, 1'b0, 2'b10, 4'd5, "R7");
    step(14'h0444, 1'b0, 1'b1, 2'b01, 4'd5, "R7");
    step(14'h0555, 1'b0, 1'b1, 2'b01, 4'd5, "R7");

    // R3: counter mode through a full wrap
    for (int i = 0; i < 65600; i++) step(14'h0, 1'b0, 1'b1, 2'b01, 4'd0, "R3");
    for (int i = 0; i < 20; i++) step(14'h0, 1'b0, (i % 2) == 0, 2'b01, 4'd2, "R3");

    // random mix of all modes and factors
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m;
      logic [3:0] d;
      m = 2'($urandom_range(0, 3));
      d = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : m_dec;
      if ($urandom_range(0, 19) != 0) m = m_mode;
      step(14'($urandom()), 1'($urandom()), 1'($urandom()), m, d, tag_of(m));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule